// File: doc/BRIEF.md
# High-Level Interrupt Return State Restorer

This block carries out the state-restore step that a CPU core performs when it retires a return from a high-level maskable interrupt handler. A one-cycle return strobe arrives with the current status word, the saved program counter and the saved status word. It also carries three interrupt status flags and a 16-bit in-service priority vector. On that strobe the block loads the saved PC and status word into its outputs. When the current status word shows no pending exception, it also clears the interrupt bookkeeping.

Bookkeeping is cleared only on a clean return, where the exception-pending bit of the current status word is 0. In that case every status flag that is set is cleared, and only the highest-priority in-service bit is removed. If the exception-pending bit is 1, the return still completes, but the flags and the in-service vector pass through untouched. All results are registered, and a done pulse marks the cycle in which they are valid.

Top module: `irq_return_ctrl`

## Requirements
- R1: A synchronous active-high reset drives pc_out, psw_out, flags_out and isr_out to zero and done to 0 on the next clock edge.
- R2: On every accepted return strobe, pc_out takes saved_pc and psw_out takes saved_psw, whatever the exception-pending bit is.
- R3: On a clean return, where bit 1 of cur_psw (the exception-pending bit) is 0, every flag is cleared, so flags_out becomes 3'b000. The flags are bit 2 (high-level nesting), bit 1 (high-level active) and bit 0 (standard-level active).
- R4: On a clean return, only the lowest-numbered set bit of isr_in is cleared in isr_out, because bit 0 is the highest priority level. All other set bits are kept.
- R5: On a clean return with isr_in equal to zero, isr_out is zero and done is still raised.
- R6: On a return with bit 1 of cur_psw equal to 1, flags_out equals flags_in and isr_out equals isr_in.
- R7: done is 1 in exactly the cycle after each cycle in which ret_req is 1, and 0 after each cycle in which ret_req is 0.
- R8: A return strobe in the cycle where done is high is taken as a new, independent return. done stays high, and the outputs reflect the second return's inputs.
- R9: In a cycle without a strobe or reset, all data outputs keep their values, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_req | input | 1 | One-cycle return strobe |
| cur_psw | input | 32 | Status word at return time; bit 1 is exception-pending |
| saved_pc | input | 32 | Saved program counter to restore |
| saved_psw | input | 32 | Saved status word to restore |
| flags_in | input | 3 | Interrupt status flags {nest, hi_active, std_active} |
| isr_in | input | 16 | In-service priority vector, bit 0 highest |
| pc_out | output | 32 | Restored program counter |
| psw_out | output | 32 | Restored status word |
| flags_out | output | 3 | Updated status flags |
| isr_out | output | 16 | Updated in-service vector |
| done | output | 1 | Return-complete pulse |

## Verification
A new return strobe can land in the same cycle as the done pulse of the previous return, so acceptance and completion overlap. The bench provokes this with two strobes on consecutive cycles, each carrying different PC, status and in-service data. It then judges that done stays high across both cycles and that the second cycle's outputs come from the second return alone. A reset asserted together with a strobe is also driven, and reset must win.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int NFLAG = 3;

  typedef struct packed {
    logic nest;
    logic hi_act;
    logic std_act;
  } rr_flags_t;

  // Tests the flags in the order nest, hi_act, std_act and clears each set one when clean.
  function automatic rr_flags_t flags_after(input rr_flags_t f, input logic clean);
    rr_flags_t r;
    r = f;
    if (clean) begin
      if (f.nest)    r.nest    = 1'b0;
      if (f.hi_act)  r.hi_act  = 1'b0;
      if (f.std_act) r.std_act = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/rr_prio_clear.sv
module rr_prio_clear #(
  parameter int NPRIO = 16
) (
  input  logic [NPRIO-1:0] isr,
  input  logic             en,
  output logic [NPRIO-1:0] clr_onehot,
  output logic             any_set,
  output logic [NPRIO-1:0] isr_next
);
  logic [NPRIO:0] seen;

  assign seen[0] = 1'b0;

  // Scan upward from bit 0 (highest priority); mark the first set bit.
  for (genvar i = 0; i < NPRIO; i++) begin : g_scan
    assign clr_onehot[i] = isr[i] & ~seen[i];
    assign seen[i+1]     = seen[i] | isr[i];
  end

  assign any_set  = seen[NPRIO];
  assign isr_next = en ? (isr & ~clr_onehot) : isr;
endmodule

// File: rtl/rr_flag_clear.sv
module rr_flag_clear
  import rr_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic             en,
  output logic [NFLAG-1:0] flags_next
);
  rr_flags_t f_in;
  rr_flags_t f_out;

  assign f_in       = rr_flags_t'(flags);
  assign f_out      = flags_after(f_in, en);
  assign flags_next = f_out;
endmodule

// File: rtl/rr_out_regs.sv
module rr_out_regs #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NF    = 3,
  parameter int NPRIO = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    pc_d,
  input  logic [DW-1:0]    psw_d,
  input  logic [NF-1:0]    flags_d,
  input  logic [NPRIO-1:0] isr_d,
  output logic [AW-1:0]    pc_q,
  output logic [DW-1:0]    psw_q,
  output logic [NF-1:0]    flags_q,
  output logic [NPRIO-1:0] isr_q,
  output logic             done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      psw_q   <= '0;
      flags_q <= '0;
      isr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= load;
      if (load) begin
        pc_q    <= pc_d;
        psw_q   <= psw_d;
        flags_q <= flags_d;
        isr_q   <= isr_d;
      end
    end
  end
endmodule

// File: rtl/irq_return_ctrl.sv
module irq_return_ctrl
  import rr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int NPRIO  = 16,
  parameter int EP_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ret_req,
  input  logic [DW-1:0]    cur_psw,
  input  logic [AW-1:0]    saved_pc,
  input  logic [DW-1:0]    saved_psw,
  input  logic [2:0]       flags_in,
  input  logic [NPRIO-1:0] isr_in,
  output logic [AW-1:0]    pc_out,
  output logic [DW-1:0]    psw_out,
  output logic [2:0]       flags_out,
  output logic [NPRIO-1:0] isr_out,
  output logic             done
);
  // Named internal events, brought out for the checker.
  logic             ep_pending;
  logic             clean_ret;
  logic             isr_any;
  logic [NPRIO-1:0] clr_onehot;
  logic [NPRIO-1:0] isr_next;
  logic [NFLAG-1:0] flags_next;

  assign ep_pending = cur_psw[EP_BIT];
  assign clean_ret  = ret_req & ~ep_pending;

  rr_prio_clear #(.NPRIO(NPRIO)) u_prio (
    .isr        (isr_in),
    .en         (clean_ret),
    .clr_onehot (clr_onehot),
    .any_set    (isr_any),
    .isr_next   (isr_next)
  );

  rr_flag_clear u_flags (
    .flags      (flags_in),
    .en         (clean_ret),
    .flags_next (flags_next)
  );

  rr_out_regs #(.AW(AW), .DW(DW), .NF(NFLAG), .NPRIO(NPRIO)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .load    (ret_req),
    .pc_d    (saved_pc),
    .psw_d   (saved_psw),
    .flags_d (flags_next),
    .isr_d   (isr_next),
    .pc_q    (pc_out),
    .psw_q   (psw_out),
    .flags_q (flags_out),
    .isr_q   (isr_out),
    .done_q  (done)
  );
endmodule

// File: rtl/rr_return_chk.sv
module rr_return_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NPRIO = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ret_req,
  input logic             ep_pending,
  input logic             clean_ret,
  input logic             isr_any,
  input logic [AW-1:0]    saved_pc,
  input logic [DW-1:0]    saved_psw,
  input logic [2:0]       flags_in,
  input logic [NPRIO-1:0] isr_in,
  input logic [AW-1:0]    pc_out,
  input logic [DW-1:0]    psw_out,
  input logic [2:0]       flags_out,
  input logic [NPRIO-1:0] isr_out,
  input logic             done
);
  // R2
  restore_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && ret_req) |=> (pc_out == $past(saved_pc) && psw_out == $past(saved_psw)));

  // R3
  flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && clean_ret) |=> (flags_out == 3'b000));

  // R4
  one_prio_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && clean_ret && isr_any) |=>
      (($countones(isr_out) + 1 == $countones($past(isr_in))) && ((isr_out & ~$past(isr_in)) == '0)));

  // R5
  empty_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && clean_ret && !isr_any) |=> (isr_out == '0 && done));

  // R6
  ep_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && ret_req && ep_pending) |=> (flags_out == $past(flags_in) && isr_out == $past(isr_in)));

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && ret_req) |=> done);

  // R7
  done_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ret_req) |=> !done);

  // R8
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && done && ret_req) |=> (done && pc_out == $past(saved_pc)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ret_req) |=> ($stable(pc_out) && $stable(psw_out) && $stable(flags_out) && $stable(isr_out)));
endmodule

bind irq_return_ctrl rr_return_chk #(.AW(AW), .DW(DW), .NPRIO(NPRIO)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ret_req    (ret_req),
  .ep_pending (ep_pending),
  .clean_ret  (clean_ret),
  .isr_any    (isr_any),
  .saved_pc   (saved_pc),
  .saved_psw  (saved_psw),
  .flags_in   (flags_in),
  .isr_in     (isr_in),
  .pc_out     (pc_out),
  .psw_out    (psw_out),
  .flags_out  (flags_out),
  .isr_out    (isr_out),
  .done       (done)
);

// File: tb/tb_irq_return_ctrl.sv
module tb_irq_return_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        ret_req;
  logic [31:0] cur_psw, saved_pc, saved_psw;
  logic [2:0]  flags_in;
  logic [15:0] isr_in;
  logic [31:0] pc_out, psw_out;
  logic [2:0]  flags_out;
  logic [15:0] isr_out;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  irq_return_ctrl dut (
    .clk(clk), .rst(rst), .ret_req(ret_req), .cur_psw(cur_psw),
    .saved_pc(saved_pc), .saved_psw(saved_psw), .flags_in(flags_in),
    .isr_in(isr_in), .pc_out(pc_out), .psw_out(psw_out),
    .flags_out(flags_out), .isr_out(isr_out), .done(done)
  );

  // {ep, flags_in, isr_in, flags_exp, isr_exp}; bit 0 of isr is highest priority.
  localparam logic [38:0] VEC [8] = '{
    {1'b0, 3'b111, 16'h0000, 3'b000, 16'h0000},
    {1'b0, 3'b101, 16'h0001, 3'b000, 16'h0000},
    {1'b0, 3'b010, 16'h8004, 3'b000, 16'h8000},
    {1'b0, 3'b000, 16'h00F0, 3'b000, 16'h00E0},
    {1'b1, 3'b111, 16'h00F0, 3'b111, 16'h00F0},
    {1'b1, 3'b011, 16'h0000, 3'b011, 16'h0000},
    {1'b0, 3'b100, 16'h8000, 3'b000, 16'h0000},
    {1'b0, 3'b001, 16'hFFFF, 3'b000, 16'hFFFE}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ep, input logic [31:0] pc, input logic [31:0] psw,
                       input logic [2:0] fl, input logic [15:0] isr);
    cur_psw   = 32'h0000_00A0 | {30'd0, ep, 1'b0};
    saved_pc  = pc;
    saved_psw = psw;
    flags_in  = fl;
    isr_in    = isr;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ret_req = 1'b0;
    drive(1'b0, 32'h0, 32'h0, 3'b111, 16'hFFFF);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pc", pc_out, 32'h0);
    chk("R1", "psw", psw_out, 32'h0);
    chk("R1", "flags", {29'd0, flags_out}, 32'h0);
    chk("R1", "isr", {16'd0, isr_out}, 32'h0);
    chk("R1", "done", {31'd0, done}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][38], 32'h1000 + 32'(i) * 4, 32'h5A00 + 32'(i), VEC[i][37:35], VEC[i][34:19]);
      ret_req = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
      // R2 restore, R3/R4/R5/R6 bookkeeping, R7 done
      chk("R2", "pc", pc_out, 32'h1000 + 32'(i) * 4);
      chk("R2", "psw", psw_out, 32'h5A00 + 32'(i));
      chk(VEC[i][38] ? "R6" : "R3", "flags", {29'd0, flags_out}, {29'd0, VEC[i][18:16]});
      chk(VEC[i][38] ? "R6" : (VEC[i][34:19] == 0 ? "R5" : "R4"), "isr",
          {16'd0, isr_out}, {16'd0, VEC[i][15:0]});
      chk("R7", "done_high", {31'd0, done}, 32'h1);
      // R9: inputs change without a strobe
      drive(1'b0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 3'b111, 16'h1234);
      @(negedge clk);
      chk("R7", "done_low", {31'd0, done}, 32'h0);
      chk("R9", "pc_hold", pc_out, 32'h1000 + 32'(i) * 4);
      chk("R9", "isr_hold", {16'd0, isr_out}, {16'd0, VEC[i][15:0]});
    end

    // R8: back-to-back strobes
    drive(1'b0, 32'h2000, 32'h11, 3'b111, 16'h0006);
    ret_req = 1'b1;
    @(negedge clk);
    chk("R8", "first_isr", {16'd0, isr_out}, 32'h0004);
    drive(1'b1, 32'h3000, 32'h22, 3'b010, 16'h0300);
    @(negedge clk);
    ret_req = 1'b0;
    chk("R8", "done_stays", {31'd0, done}, 32'h1);
    chk("R8", "second_pc", pc_out, 32'h3000);
    chk("R8", "second_psw", psw_out, 32'h22);
    chk("R8", "second_flags", {29'd0, flags_out}, 32'h2);
    chk("R8", "second_isr", {16'd0, isr_out}, 32'h0300);
    @(negedge clk);
    chk("R7", "done_drop", {31'd0, done}, 32'h0);

    // R1: reset wins over a simultaneous strobe
    drive(1'b1, 32'h4000, 32'h33, 3'b111, 16'hFFFF);
    ret_req = 1'b1; rst = 1'b1;
    @(negedge clk);
    ret_req = 1'b0; rst = 1'b0;
    chk("R1", "pc_rst", pc_out, 32'h0);
    chk("R1", "isr_rst", {16'd0, isr_out}, 32'h0);
    chk("R1", "done_rst", {31'd0, done}, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule